// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the central sequencer that moves a chip between its supply-domain operating modes. Five supplies exist: two of them (the memory-network supply and the always-on supply) are never switched, so this block drives nothing for them. The other three switchable domains, called SOC, TM and DBG here, each get an active-low isolation clamp enable, a one-cycle state save pulse, a one-cycle state restore pulse and a power switch enable. The physical switch for each domain answers with an acknowledge input that follows its enable after some delay.

Software presents a mode code with a one-cycle request strobe. The controller checks the code, then runs power-down and power-up legs one domain at a time. Any move between two reduced modes first restores the full-on mode and only then removes the new domain. A switch that does not answer within a programmable number of cycles makes the controller back out to the last stable condition and raise a sticky timeout flag.

Top module: `pm_seq_ctrl`

## Requirements
- R1: After reset the mode is all_on (code 0), every clamp enable and every switch enable is 1, save, restore, busy and both error flags are 0.
- R2: Mode codes are 0 all_on, 1 dbg_off, 2 tm_off, 3 soc_off; domain bit 0 is SOC, bit 1 TM, bit 2 DBG. When idle, exactly the domain named by the mode has its switch enable and clamp enable at 0, and in all_on every switch enable is 1.
- R3: Power-down of a domain: its clamp enable falls, in the next cycle its save pulse is high for one cycle, in the cycle after that its switch enable falls; the mode changes once the acknowledge is seen low. A domain's clamp enable is low whenever its switch enable is low.
- R4: Power-up of a domain: its switch enable rises, the controller waits for the acknowledge high, then the restore pulse is high for one cycle, and in the next cycle the clamp enable returns to 1 and the mode becomes all_on.
- R5: A change between two reduced modes first powers the current domain up, reports all_on, then powers the new domain down; at no time is more than one clamp enable low.
- R6: busy is high from the cycle after a request is accepted until the cycle after the final acknowledge or clamp release; requests made while busy are ignored, and a request for the current mode starts nothing and leaves busy low.
- R7: A request with a code from 4 to 7 is ignored (mode and outputs unchanged) and sets the mode error flag, which then stays set until reset.
- R8: In a power-down wait, if the acknowledge is still high in the wait cycle whose counter value reaches the limit input (limit+1 wait cycles), the timeout flag is set and stays set, the switch is enabled again, the domain is powered up and the mode ends as all_on; a switch answering in limit cycles does not time out.
- R9: In a power-up wait, if the acknowledge does not rise within limit+1 wait cycles, the timeout flag is set, the switch enable is dropped, the clamp stays low and the mode ends as the mode with that domain off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| tmo_limit | input | CNT_W | Acknowledge wait limit in cycles |
| sw_ack | input | 3 | Power switch acknowledge per domain |
| clamp_n | output | 3 | Isolation clamp enable per domain, active low |
| sw_en | output | 3 | Power switch enable per domain |
| save | output | 3 | State save pulse per domain |
| restore | output | 3 | State restore pulse per domain |
| cur_mode | output | 3 | Current stable mode code |
| busy | output | 1 | Sequence in progress |
| mode_err | output | 1 | Sticky invalid-code flag |
| tmo_err | output | 1 | Sticky acknowledge timeout flag |

## Verification
The bench builds the controller with CNT_W set to 4 and drives a limit of 5, so a full timeout takes only six wait cycles and both timeout paths plus the exact limit boundary fit in a short run. A switch model in the bench answers each enable after a programmable delay or holds its acknowledge stuck, which reaches the abort of a power-down, the failed power-up and the case where the switch answers just in time at a delay of four.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;

   localparam int MODE_W  = 3;
   localparam int NUM_DOM = 3;
   localparam int DOM_W   = 2;

   typedef logic [MODE_W-1:0] mode_t;
   typedef logic [DOM_W-1:0]  dom_t;

   localparam mode_t MODE_ALL_ON = 3'd0;
   localparam mode_t MODE_MAX    = 3'd3;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_CLAMP, CMD_SAVE, CMD_SWOFF, CMD_SWON, CMD_RESTORE, CMD_RELEASE
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DN_CLAMP, ST_DN_SAVE, ST_DN_OFF, ST_DN_WAIT, ST_UP_WAIT, ST_UP_REST
   } state_e;

   // a legal code names at most one domain that is off
   function automatic logic mode_ok(mode_t m);
      return m <= MODE_MAX;
   endfunction

   // domain switched off in a reduced mode: code 3 -> 0, 2 -> 1, 1 -> 2
   function automatic dom_t mode_dom(mode_t m);
      return DOM_W'(MODE_MAX - m);
   endfunction

   function automatic mode_t dom_mode(dom_t d);
      return MODE_MAX - {1'b0, d};
   endfunction

endpackage

// File: rtl/pm_wait_timer.sv
module pm_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("pm_wait_timer: CNT_W must lie in 1..32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign expired = run && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clr)             cnt <= '0;
      else if (run && !expired) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pm_domain_ctl.sv
module pm_domain_ctl
   import pm_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  cmd_e cmd,
   output logic clamp_n,
   output logic sw_en,
   output logic save,
   output logic restore
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clamp_n <= 1'b1;
         sw_en   <= 1'b1;
         save    <= 1'b0;
         restore <= 1'b0;
      end else begin
         save    <= sel && (cmd == CMD_SAVE);
         restore <= sel && (cmd == CMD_RESTORE);
         if (sel) begin
            case (cmd)
               CMD_CLAMP:   clamp_n <= 1'b0;
               CMD_RELEASE: clamp_n <= 1'b1;
               CMD_SWOFF:   sw_en   <= 1'b0;
               CMD_SWON:    sw_en   <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   AST_OFF_IS_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |-> !clamp_n);  // R3

   AST_SAVE_THEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      save |=> !sw_en);  // R3

   AST_RESTORE_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> (clamp_n && !restore));  // R4

endmodule

// File: rtl/pm_seq_ctrl.sv
module pm_seq_ctrl
   import pm_seq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [MODE_W-1:0]   req_mode,
   input  logic [CNT_W-1:0]    tmo_limit,
   input  logic [NUM_DOM-1:0]  sw_ack,
   output logic [NUM_DOM-1:0]  clamp_n,
   output logic [NUM_DOM-1:0]  sw_en,
   output logic [NUM_DOM-1:0]  save,
   output logic [NUM_DOM-1:0]  restore,
   output logic [MODE_W-1:0]   cur_mode,
   output logic                busy,
   output logic                mode_err,
   output logic                tmo_err
);

   generate
      if (NUM_DOM != 3 || MODE_W != 3) begin : g_bad_table
         $error("pm_seq_ctrl: the mode table is built for three switchable domains");
      end
   endgenerate

   state_e state, state_n;
   dom_t   dom, dom_n, cmd_dom;
   mode_t  tgt, tgt_n, mode_n;
   logic   abort, abort_n, merr_n, terr_n;
   cmd_e   cmd;
   logic   ack_sel, expired, in_wait;

   assign ack_sel = sw_ack[dom];
   assign in_wait = (state == ST_DN_WAIT) || (state == ST_UP_WAIT);
   assign busy    = (state != ST_IDLE);

   pm_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state_n != state),
      .run     (in_wait),
      .limit   (tmo_limit),
      .expired (expired)
   );

   always_comb begin
      state_n = state;
      dom_n   = dom;
      tgt_n   = tgt;
      abort_n = abort;
      mode_n  = cur_mode;
      merr_n  = mode_err;
      terr_n  = tmo_err;
      cmd     = CMD_NONE;
      cmd_dom = dom;
      case (state)
         ST_IDLE: begin
            if (req_valid) begin
               if (!mode_ok(req_mode)) begin
                  merr_n = 1'b1;
               end else if (req_mode != cur_mode) begin
                  tgt_n   = req_mode;
                  abort_n = 1'b0;
                  if (cur_mode != MODE_ALL_ON) begin
                     cmd     = CMD_SWON;
                     cmd_dom = mode_dom(cur_mode);
                     dom_n   = mode_dom(cur_mode);
                     state_n = ST_UP_WAIT;
                  end else begin
                     cmd     = CMD_CLAMP;
                     cmd_dom = mode_dom(req_mode);
                     dom_n   = mode_dom(req_mode);
                     state_n = ST_DN_SAVE;
                  end
               end
            end
         end
         ST_DN_CLAMP: begin
            cmd     = CMD_CLAMP;
            state_n = ST_DN_SAVE;
         end
         ST_DN_SAVE: begin
            cmd     = CMD_SAVE;
            state_n = ST_DN_OFF;
         end
         ST_DN_OFF: begin
            cmd     = CMD_SWOFF;
            state_n = ST_DN_WAIT;
         end
         ST_DN_WAIT: begin
            if (!ack_sel) begin
               mode_n  = dom_mode(dom);
               state_n = ST_IDLE;
            end else if (expired) begin
               terr_n  = 1'b1;
               abort_n = 1'b1;
               cmd     = CMD_SWON;
               state_n = ST_UP_WAIT;
            end
         end
         ST_UP_WAIT: begin
            if (ack_sel) begin
               cmd     = CMD_RESTORE;
               state_n = ST_UP_REST;
            end else if (expired) begin
               terr_n  = 1'b1;
               cmd     = CMD_SWOFF;
               mode_n  = dom_mode(dom);
               state_n = ST_IDLE;
            end
         end
         ST_UP_REST: begin
            cmd    = CMD_RELEASE;
            mode_n = MODE_ALL_ON;
            if (!abort && tgt != MODE_ALL_ON) begin
               dom_n   = mode_dom(tgt);
               state_n = ST_DN_CLAMP;
            end else begin
               state_n = ST_IDLE;
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dom      <= '0;
         tgt      <= MODE_ALL_ON;
         abort    <= 1'b0;
         cur_mode <= MODE_ALL_ON;
         mode_err <= 1'b0;
         tmo_err  <= 1'b0;
      end else begin
         state    <= state_n;
         dom      <= dom_n;
         tgt      <= tgt_n;
         abort    <= abort_n;
         cur_mode <= mode_n;
         mode_err <= merr_n;
         tmo_err  <= terr_n;
      end
   end

   for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
      pm_domain_ctl u_dom (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (cmd_dom == DOM_W'(i)),
         .cmd     (cmd),
         .clamp_n (clamp_n[i]),
         .sw_en   (sw_en[i]),
         .save    (save[i]),
         .restore (restore[i])
      );
   end

   AST_ONE_DOMAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~clamp_n) <= 1);  // R5

   AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_mode <= MODE_MAX);  // R2

   AST_IDLE_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((&sw_en) == (cur_mode == MODE_ALL_ON)));  // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (save == '0 && restore == '0));  // R6

   AST_MODE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> mode_err);  // R7

   AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |=> tmo_err);  // R8

endmodule

// File: tb/test_pm_seq_ctrl.sv
module test_pm_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 4;
   localparam int LIMIT      = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_mode = '0;
   logic [CW-1:0] tmo_limit = CW'(LIMIT);
   logic [2:0]    sw_ack;
   logic [2:0]    clamp_n, sw_en, save, restore, cur_mode;
   logic          busy, mode_err, tmo_err;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pm_seq_ctrl #(.CNT_W(CW)) i_pm_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .tmo_limit(tmo_limit), .sw_ack(sw_ack), .clamp_n(clamp_n), .sw_en(sw_en),
      .save(save), .restore(restore), .cur_mode(cur_mode), .busy(busy),
      .mode_err(mode_err), .tmo_err(tmo_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // switch plant: acknowledge follows the enable after plant_dly+1 edges
   int plant_dly = 1;
   bit [2:0] stuck = '0;
   int pc [3];
   always @(posedge clk) begin
      if (!rst_n) begin
         sw_ack <= 3'b111;
         for (int d = 0; d < 3; d++) pc[d] = 0;
      end else begin
         for (int d = 0; d < 3; d++) begin
            if (stuck[d]) pc[d] = 0;
            else if (sw_en[d] != sw_ack[d]) begin
               if (pc[d] >= plant_dly) begin sw_ack[d] <= sw_en[d]; pc[d] = 0; end
               else pc[d]++;
            end else pc[d] = 0;
         end
      end
   end

   // behavioural reference: queue of steps, op*4+domain
   // ops 0 clamp, 1 save, 2 off, 3 wait low, 4 on, 5 wait high, 6 release
   int q[$];
   bit [2:0] m_clamp, m_sw, m_save, m_rest;
   int m_mode, wcnt;
   bit m_err, m_to;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_clamp = 3'b111; m_sw = 3'b111; m_save = '0; m_rest = '0;
         m_mode = 0; wcnt = 0; m_err = 0; m_to = 0;
      end else begin
         m_save = '0; m_rest = '0;
         if (q.size() == 0 && req_valid) begin
            if (req_mode > 3) m_err = 1;
            else if (int'(req_mode) != m_mode) begin
               if (m_mode != 0) begin
                  q.push_back(16 + 3 - m_mode); q.push_back(20 + 3 - m_mode);
                  q.push_back(24 + 3 - m_mode);
               end
               if (req_mode != 0) begin
                  q.push_back(0 + 3 - req_mode); q.push_back(4 + 3 - req_mode);
                  q.push_back(8 + 3 - req_mode); q.push_back(12 + 3 - req_mode);
               end
            end
         end
         if (q.size() > 0) begin
            int op, d;
            op = q[0] / 4; d = q[0] % 4;
            case (op)
               0: begin m_clamp[d] = 0; void'(q.pop_front()); end
               1: begin m_save[d] = 1; void'(q.pop_front()); end
               2: begin m_sw[d] = 0; wcnt = 0; void'(q.pop_front()); end
               3: if (!sw_ack[d]) begin m_mode = 3 - d; void'(q.pop_front()); end
                  else if (wcnt >= LIMIT) begin
                     m_to = 1; m_sw[d] = 1; wcnt = 0; q.delete();
                     q.push_back(20 + d); q.push_back(24 + d);
                  end else wcnt++;
               4: begin m_sw[d] = 1; wcnt = 0; void'(q.pop_front()); end
               5: if (sw_ack[d]) begin m_rest[d] = 1; void'(q.pop_front()); end
                  else if (wcnt >= LIMIT) begin
                     m_to = 1; m_sw[d] = 0; m_mode = 3 - d; q.delete();
                  end else wcnt++;
               default: begin m_clamp[d] = 1; m_mode = 0; void'(q.pop_front()); end
            endcase
         end
      end
   end

   // every-cycle comparison and event monitor
   int cyc = 0;
   int t_clamp_dn, t_save, t_sw_dn, t_sw_up, t_rest, t_clamp_up;
   bit saw_all_on, many_down;
   logic [2:0] p_clamp = 3'b111, p_sw = 3'b111;
   always @(posedge clk) cyc++;
   always @(negedge clk) begin
      if (rst_n) begin
         chk(clamp_n == m_clamp, "R2 clamp_n", clamp_n, m_clamp);
         chk(sw_en == m_sw, "R2 sw_en", sw_en, m_sw);
         chk(save == m_save, "R3 save", save, m_save);
         chk(restore == m_rest, "R4 restore", restore, m_rest);
         chk(int'(cur_mode) == m_mode, "R5 cur_mode", cur_mode, m_mode);
         chk(busy == (q.size() > 0), "R6 busy", busy, q.size() > 0);
         chk(mode_err == m_err, "R7 mode_err", mode_err, m_err);
         chk(tmo_err == m_to, "R8 tmo_err", tmo_err, m_to);
         if ((p_clamp & ~clamp_n) != 0) t_clamp_dn = cyc;
         if ((~p_clamp & clamp_n) != 0) t_clamp_up = cyc;
         if ((p_sw & ~sw_en) != 0) t_sw_dn = cyc;
         if ((~p_sw & sw_en) != 0) t_sw_up = cyc;
         if (save != 0) t_save = cyc;
         if (restore != 0) t_rest = cyc;
         if (busy && cur_mode == 0) saw_all_on = 1;
         if ($countones(~clamp_n) > 1) many_down = 1;
         p_clamp = clamp_n; p_sw = sw_en;
      end
   end

   task automatic req(input int m);
      @(negedge clk); req_valid = 1'b1; req_mode = 3'(m);
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cur_mode == 0 && busy == 0, "R1 mode/busy", cur_mode, 0);
      chk(clamp_n == 3'b111 && sw_en == 3'b111, "R1 clamp/sw", {clamp_n, sw_en}, 6'b111111);
      chk(save == 0 && restore == 0 && mode_err == 0 && tmo_err == 0, "R1 pulses/flags",
          {save, restore, mode_err, tmo_err}, 0);

      // dbg_off from all_on
      req(1); wait_idle();
      chk(cur_mode == 1 && sw_en == 3'b011 && clamp_n == 3'b011, "R2 dbg_off table",
          {cur_mode, sw_en, clamp_n}, {3'd1, 3'b011, 3'b011});
      chk(t_save == t_clamp_dn + 1 && t_sw_dn == t_save + 1, "R3 down order",
          t_sw_dn - t_clamp_dn, 2);

      // dbg_off -> tm_off through all_on
      saw_all_on = 0; many_down = 0;
      req(2); wait_idle();
      chk(cur_mode == 2 && sw_en == 3'b101, "R5 tm_off reached", {cur_mode, sw_en}, {3'd2, 3'b101});
      chk(saw_all_on && !many_down, "R5 via all_on", {saw_all_on, many_down}, 2'b10);

      // request while busy is ignored
      req(3); @(negedge clk); req(0); wait_idle();
      chk(cur_mode == 3 && sw_en == 3'b110, "R6 busy holds off", cur_mode, 3);

      // same mode: nothing starts
      req(3); @(negedge clk);
      chk(busy == 0 && cur_mode == 3, "R6 same mode", busy, 0);

      // invalid code
      req(6); @(negedge clk);
      chk(mode_err == 1 && cur_mode == 3 && busy == 0, "R7 invalid code",
          {mode_err, cur_mode}, {1'b1, 3'd3});

      // back to all_on
      req(0); wait_idle();
      chk(cur_mode == 0 && sw_en == 3'b111 && clamp_n == 3'b111, "R4 all_on restored",
          {cur_mode, sw_en, clamp_n}, {3'd0, 6'b111111});
      chk(t_clamp_up == t_rest + 1 && t_rest > t_sw_up, "R4 up order", t_clamp_up - t_rest, 1);

      // boundary: switch answers at the limit
      plant_dly = LIMIT - 1;
      req(2); wait_idle();
      chk(cur_mode == 2 && tmo_err == 0, "R8 answer at limit", {cur_mode, tmo_err}, {3'd2, 1'b0});
      req(0); wait_idle();
      chk(cur_mode == 0 && tmo_err == 0, "R4 slow up", cur_mode, 0);

      // power-down timeout
      plant_dly = 1; stuck = 3'b100;
      req(1); wait_idle();
      chk(tmo_err == 1 && cur_mode == 0 && sw_en == 3'b111 && clamp_n == 3'b111,
          "R8 down timeout", {tmo_err, cur_mode, sw_en}, {1'b1, 3'd0, 3'b111});

      // power-up timeout
      stuck = 3'b000;
      req(1); wait_idle();
      chk(cur_mode == 1, "R2 dbg_off again", cur_mode, 1);
      stuck = 3'b100;
      req(0); wait_idle();
      chk(cur_mode == 1 && sw_en[2] == 0 && clamp_n[2] == 0, "R9 up timeout",
          {cur_mode, sw_en[2], clamp_n[2]}, {3'd1, 2'b00});

      stuck = 3'b000;
      req(0); wait_idle();
      chk(cur_mode == 0 && sw_en == 3'b111 && mode_err == 1, "R7 sticky after recovery",
          {cur_mode, sw_en, mode_err}, {3'd0, 3'b111, 1'b1});

      finish_run();
   end

endmodule